// File: doc/BRIEF.md
# Counter CSR Access Permission Checker

This block rules on every attempt to read a user-level counter CSR (cycle, time, instret, hpmcounter3 through hpmcounter31, and the RV32 upper halves of each). For every strobed access it looks at the current privilege level, the CSR address and whether the instruction intends to write. In the same cycle it answers either with a grant or with an illegal-instruction flag and the faulting address.

Two 32-bit enable masks decide the answer. Machine software writes them: the machine mask gates the level just below machine mode, and the supervisor mask also gates user mode. Bit n of each mask belongs to the counter whose address ends in n. A small cycle counter and a retired-instruction counter sit alongside the masks. They show that the enable settings never stop the counters, and that a faulting access does not retire.

Top module: `ctr_access_guard`

## Requirements
- R1: After reset both enable masks read as zero and both event counters read as zero.
- R2: With privilege code 2'b11 (machine), a read of any counter address is granted whatever the masks hold.
- R3: With privilege code 2'b01 (supervisor) and supervisor mode present, a read is granted exactly when machine-mask bit addr[4:0] is 1. Otherwise it is flagged illegal.
- R4: With privilege code 2'b00 (user) and supervisor mode present, a read is granted only when bit addr[4:0] is 1 in both masks. Code 2'b10 is treated as user.
- R5: Counter addresses are 0xC00–0xC1F (low halves) and 0xC80–0xC9F (high halves). A high-half address uses the same mask bit as the low half with the same addr[4:0].
- R6: An access with write intent to a counter address is flagged illegal at every privilege level, including machine, and is never granted.
- R7: An access to an address outside both counter ranges produces neither grant nor illegal flag.
- R8: With the access strobe low, grant and illegal are both 0. The fault address output equals the access address while illegal is 1, and is zero otherwise.
- R9: A mask write (select 0 = machine mask, 1 = supervisor mask) takes effect at the next clock edge. An access in the same cycle as the write is judged with the old mask value.
- R10: The cycle counter increments by one every clock after reset, whatever the mask writes and accesses are.
- R11: The retired counter increments on a retire pulse, except in a cycle where the illegal flag is raised. In that cycle it holds its value.
- R12: With supervisor mode absent, the machine mask alone grants access to every non-machine level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| acc_valid_i | input | 1 | Counter CSR access strobe |
| acc_priv_i | input | 2 | Current privilege code (00 user, 01 supervisor, 11 machine) |
| acc_addr_i | input | 12 | CSR address of the access |
| acc_write_i | input | 1 | Access intends to write the CSR |
| mask_we_i | input | 1 | Enable-mask write strobe |
| mask_sel_i | input | 1 | 0 selects the machine mask, 1 the supervisor mask |
| mask_wdata_i | input | 32 | Enable-mask write data |
| retire_i | input | 1 | Instruction retire pulse |
| m_mask_o | output | 32 | Current machine enable mask |
| s_mask_o | output | 32 | Current supervisor enable mask |
| grant_o | output | 1 | Access permitted |
| illegal_o | output | 1 | Access raises illegal instruction |
| fault_addr_o | output | 12 | Address of the faulting access, else zero |
| cycle_o | output | CNT_W | Free-running cycle count |
| retired_o | output | CNT_W | Retired-instruction count |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a retire pulse arrives in the same cycle as a faulting access. The bench drives both together and expects the retired count to hold, then repeats with a legal access and expects it to advance by exactly one. In the second, a mask write arrives together with an access that the write would change. The bench expects the verdict to follow the old mask in that cycle and the new mask one cycle later, while the cycle counter advances without a gap throughout.

// File: rtl/ctr_guard_pkg.sv
package ctr_guard_pkg;

    typedef enum logic [1:0] {
        PRIV_U    = 2'b00,
        PRIV_S    = 2'b01,
        PRIV_RSVD = 2'b10,
        PRIV_M    = 2'b11
    } priv_e;

    localparam int unsigned  MASK_W    = 32;
    localparam int unsigned  CSR_AW    = 12;
    localparam int unsigned  IDX_W     = $clog2(MASK_W);
    localparam logic [3:0]   CTR_PAGE  = 4'hC;
    localparam logic [2:0]   BANK_LO   = 3'b000;
    localparam logic [2:0]   BANK_HI   = 3'b100;

    localparam logic         SEL_MACH  = 1'b0;
    localparam logic         SEL_SUPV  = 1'b1;

    typedef struct packed {
        logic [MASK_W-1:0] m_en;
        logic [MASK_W-1:0] s_en;
    } mask_state_t;

endpackage

// File: rtl/ctr_enable_regs.sv
module ctr_enable_regs
    import ctr_guard_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic              sel_i,
    input  logic [MASK_W-1:0] wdata_i,
    output logic [MASK_W-1:0] m_en_o,
    output logic [MASK_W-1:0] s_en_o
);

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            if (sel_i == SEL_SUPV) st_d.s_en = wdata_i;
            else                   st_d.m_en = wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign m_en_o = st_q.m_en;
    assign s_en_o = st_q.s_en;

endmodule

// File: rtl/ctr_perm_decode.sv
module ctr_perm_decode
    import ctr_guard_pkg::*;
#(
    parameter bit HAS_SMODE = 1'b1
) (
    input  logic              valid_i,
    input  logic [1:0]        priv_i,
    input  logic [CSR_AW-1:0] addr_i,
    input  logic              write_i,
    input  logic [MASK_W-1:0] m_en_i,
    input  logic [MASK_W-1:0] s_en_i,
    output logic              grant_o,
    output logic              illegal_o,
    output logic [CSR_AW-1:0] fault_addr_o
);

    logic             page_hit;
    logic [2:0]       bank;
    logic             in_range;
    logic [IDX_W-1:0] idx;
    logic             m_bit;
    logic             s_bit;
    logic             permitted;
    priv_e            lvl;

    assign lvl      = priv_e'(priv_i);
    assign page_hit = (addr_i[11:8] == CTR_PAGE);
    assign bank     = addr_i[7:5];
    assign in_range = page_hit && ((bank == BANK_LO) || (bank == BANK_HI));
    assign idx      = addr_i[IDX_W-1:0];
    assign m_bit    = m_en_i[idx];
    assign s_bit    = s_en_i[idx];

    generate
        if (HAS_SMODE) begin : g_three_level
            always_comb begin
                unique case (lvl)
                    PRIV_M:  permitted = 1'b1;
                    PRIV_S:  permitted = m_bit;
                    default: permitted = m_bit && s_bit;
                endcase
            end
        end else begin : g_two_level
            always_comb begin
                permitted = (lvl == PRIV_M) ? 1'b1 : m_bit;
            end
        end
    endgenerate

    always_comb begin
        grant_o      = 1'b0;
        illegal_o    = 1'b0;
        fault_addr_o = '0;
        if (valid_i && in_range) begin
            if (write_i || !permitted) begin
                illegal_o    = 1'b1;
                fault_addr_o = addr_i;
            end else begin
                grant_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ctr_event_counters.sv
module ctr_event_counters #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             retire_i,
    input  logic             squash_i,
    output logic [CNT_W-1:0] cycle_o,
    output logic [CNT_W-1:0] retired_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cycles;
        logic [CNT_W-1:0] retired;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.cycles = st_q.cycles + 1'b1;
        if (retire_i && !squash_i) begin
            st_d.retired = st_q.retired + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cycle_o   = st_q.cycles;
    assign retired_o = st_q.retired;

endmodule

// File: rtl/ctr_access_guard.sv
module ctr_access_guard
    import ctr_guard_pkg::*;
#(
    parameter bit          HAS_SMODE = 1'b1,
    parameter int unsigned CNT_W     = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             acc_valid_i,
    input  logic [1:0]       acc_priv_i,
    input  logic [11:0]      acc_addr_i,
    input  logic             acc_write_i,
    input  logic             mask_we_i,
    input  logic             mask_sel_i,
    input  logic [31:0]      mask_wdata_i,
    input  logic             retire_i,
    output logic [31:0]      m_mask_o,
    output logic [31:0]      s_mask_o,
    output logic             grant_o,
    output logic             illegal_o,
    output logic [11:0]      fault_addr_o,
    output logic [CNT_W-1:0] cycle_o,
    output logic [CNT_W-1:0] retired_o
);

    logic [MASK_W-1:0] m_en;
    logic [MASK_W-1:0] s_en;
    logic              illegal;

    ctr_enable_regs u_masks (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (mask_we_i),
        .sel_i   (mask_sel_i),
        .wdata_i (mask_wdata_i),
        .m_en_o  (m_en),
        .s_en_o  (s_en)
    );

    ctr_perm_decode #(
        .HAS_SMODE (HAS_SMODE)
    ) u_decode (
        .valid_i      (acc_valid_i),
        .priv_i       (acc_priv_i),
        .addr_i       (acc_addr_i),
        .write_i      (acc_write_i),
        .m_en_i       (m_en),
        .s_en_i       (s_en),
        .grant_o      (grant_o),
        .illegal_o    (illegal),
        .fault_addr_o (fault_addr_o)
    );

    ctr_event_counters #(
        .CNT_W (CNT_W)
    ) u_counters (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .retire_i  (retire_i),
        .squash_i  (illegal),
        .cycle_o   (cycle_o),
        .retired_o (retired_o)
    );

    assign illegal_o = illegal;
    assign m_mask_o  = m_en;
    assign s_mask_o  = s_en;

endmodule

// File: rtl/ctr_access_guard_chk.sv
module ctr_access_guard_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             acc_valid_i,
    input logic [1:0]       acc_priv_i,
    input logic [11:0]      acc_addr_i,
    input logic             acc_write_i,
    input logic             mask_we_i,
    input logic             mask_sel_i,
    input logic [31:0]      mask_wdata_i,
    input logic             retire_i,
    input logic [31:0]      m_mask_o,
    input logic [31:0]      s_mask_o,
    input logic             grant_o,
    input logic             illegal_o,
    input logic [11:0]      fault_addr_o,
    input logic [CNT_W-1:0] cycle_o,
    input logic [CNT_W-1:0] retired_o
);

    logic ctr_addr;
    assign ctr_addr = (acc_addr_i[11:8] == 4'hC) &&
                      ((acc_addr_i[7:5] == 3'b000) || (acc_addr_i[7:5] == 3'b100));

    AST_MACHINE_READ_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_valid_i && ctr_addr && !acc_write_i && acc_priv_i == 2'b11) |-> grant_o); // R2

    AST_WRITE_TRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_valid_i && ctr_addr && acc_write_i) |-> (illegal_o && !grant_o)); // R6

    AST_FOREIGN_ADDR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_valid_i && !ctr_addr) |-> (!illegal_o && !grant_o)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !acc_valid_i |-> (!illegal_o && !grant_o && fault_addr_o == 12'h000)); // R8

    AST_FAULT_ADDR_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |-> (fault_addr_o == acc_addr_i)); // R8

    AST_MASK_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_we_i && mask_sel_i == 1'b0) |=> (m_mask_o == $past(mask_wdata_i))); // R9

    AST_CYCLE_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> (cycle_o == $past(cycle_o) + 1'b1)); // R10

    AST_FAULT_NO_RETIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (retire_i && illegal_o) |=> $stable(retired_o)); // R11

    AST_RETIRE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_ni && retire_i && !illegal_o) |=> (retired_o == $past(retired_o) + 1'b1)); // R11

endmodule

bind ctr_access_guard ctr_access_guard_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .acc_valid_i  (acc_valid_i),
    .acc_priv_i   (acc_priv_i),
    .acc_addr_i   (acc_addr_i),
    .acc_write_i  (acc_write_i),
    .mask_we_i    (mask_we_i),
    .mask_sel_i   (mask_sel_i),
    .mask_wdata_i (mask_wdata_i),
    .retire_i     (retire_i),
    .m_mask_o     (m_mask_o),
    .s_mask_o     (s_mask_o),
    .grant_o      (grant_o),
    .illegal_o    (illegal_o),
    .fault_addr_o (fault_addr_o),
    .cycle_o      (cycle_o),
    .retired_o    (retired_o)
);

// File: tb/ctr_access_guard_test.sv
`timescale 1ns/1ps
module ctr_access_guard_test;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             valid = 1'b0;
    logic [1:0]       priv = 2'b11;
    logic [11:0]      addr = 12'h000;
    logic             wr = 1'b0;
    logic             mwe = 1'b0;
    logic             msel = 1'b0;
    logic [31:0]      mdata = '0;
    logic             retire = 1'b0;

    logic [31:0]      m_mask, s_mask, m_mask_n, s_mask_n;
    logic             grant, illegal, grant_n, illegal_n;
    logic [11:0]      faddr, faddr_n;
    logic [CNT_W-1:0] cyc, ret, cyc_n, ret_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    ctr_access_guard #(.HAS_SMODE(1'b1), .CNT_W(CNT_W)) uut (
        .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .acc_priv_i(priv),
        .acc_addr_i(addr), .acc_write_i(wr), .mask_we_i(mwe), .mask_sel_i(msel),
        .mask_wdata_i(mdata), .retire_i(retire), .m_mask_o(m_mask), .s_mask_o(s_mask),
        .grant_o(grant), .illegal_o(illegal), .fault_addr_o(faddr),
        .cycle_o(cyc), .retired_o(ret)
    );

    ctr_access_guard #(.HAS_SMODE(1'b0), .CNT_W(CNT_W)) uut_nos (
        .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .acc_priv_i(priv),
        .acc_addr_i(addr), .acc_write_i(wr), .mask_we_i(mwe), .mask_sel_i(msel),
        .mask_wdata_i(mdata), .retire_i(retire), .m_mask_o(m_mask_n), .s_mask_o(s_mask_n),
        .grant_o(grant_n), .illegal_o(illegal_n), .fault_addr_o(faddr_n),
        .cycle_o(cyc_n), .retired_o(ret_n)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive an access after a falling edge, then let combinational logic settle
    task automatic access(input logic [1:0] p, input logic [11:0] a, input logic w);
        @(negedge clk);
        valid = 1'b1; priv = p; addr = a; wr = w;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        valid = 1'b0; wr = 1'b0; retire = 1'b0; mwe = 1'b0;
        #1;
    endtask

    task automatic set_mask(input logic sel, input logic [31:0] val);
        @(negedge clk);
        mwe = 1'b1; msel = sel; mdata = val;
        @(negedge clk);
        mwe = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 m mask", m_mask, 0);
        check("R1 s mask", s_mask, 0);
        check("R1 retired", ret, 0);
        check("R1 cycle", cyc, 0);
    endtask

    task automatic t_machine();
        access(2'b11, 12'hC00, 1'b0); check("R2 cycle grant", grant, 1);
        access(2'b11, 12'hC1F, 1'b0); check("R2 hpm31 grant", grant, 1);
        check("R2 no illegal", illegal, 0);
        idle();
    endtask

    task automatic t_smode();
        set_mask(1'b0, 32'h0000_0009); // CY and HPM3
        access(2'b01, 12'hC03, 1'b0); check("R3 hpm3 grant", grant, 1);
        access(2'b01, 12'hC02, 1'b0); check("R3 instret illegal", illegal, 1);
        check("R3 instret grant", grant, 0);
        idle();
    endtask

    task automatic t_umode();
        set_mask(1'b1, 32'h0000_0001); // supervisor: CY only
        access(2'b00, 12'hC00, 1'b0); check("R4 cycle grant", grant, 1);
        access(2'b00, 12'hC03, 1'b0); check("R4 hpm3 needs s bit", illegal, 1);
        access(2'b10, 12'hC03, 1'b0); check("R4 reserved as user", illegal, 1);
        access(2'b01, 12'hC03, 1'b0); check("R4 S unaffected by s mask", grant, 1);
        idle();
    endtask

    task automatic t_high();
        access(2'b01, 12'hC83, 1'b0); check("R5 hpm3h grant", grant, 1);
        access(2'b00, 12'hC83, 1'b0); check("R5 hpm3h user illegal", illegal, 1);
        check("R8 fault addr", faddr, 12'hC83);
        access(2'b00, 12'hC80, 1'b0); check("R5 cycleh user grant", grant, 1);
        idle();
    endtask

    task automatic t_write();
        access(2'b11, 12'hC00, 1'b1); check("R6 machine write illegal", illegal, 1);
        check("R6 machine write grant", grant, 0);
        access(2'b00, 12'hC00, 1'b1); check("R6 user write illegal", illegal, 1);
        idle();
    endtask

    task automatic t_range();
        access(2'b00, 12'hC40, 1'b0);
        check("R7 gap grant", grant, 0); check("R7 gap illegal", illegal, 0);
        access(2'b00, 12'h300, 1'b1);
        check("R7 foreign illegal", illegal, 0);
        check("R8 fault addr zero", faddr, 0);
        idle();
    endtask

    task automatic t_strobe();
        @(negedge clk);
        valid = 1'b0; priv = 2'b00; addr = 12'hC05; wr = 1'b1; #1;
        check("R8 idle illegal", illegal, 0);
        check("R8 idle grant", grant, 0);
        check("R8 idle addr", faddr, 0);
        idle();
    endtask

    task automatic t_cfg_same_cycle();
        logic [CNT_W-1:0] c0;
        c0 = cyc;
        @(negedge clk);
        valid = 1'b1; priv = 2'b01; addr = 12'hC04; wr = 1'b0;
        mwe = 1'b1; msel = 1'b0; mdata = 32'h0000_0019; #1;
        check("R9 old mask this cycle", illegal, 1);
        @(negedge clk);
        mwe = 1'b0; #1;
        check("R9 new mask next cycle", grant, 1);
        check("R9 mask value", m_mask, 32'h0000_0019);
        check("R10 cycle through write", cyc, CNT_W'(c0 + 2));
        idle();
    endtask

    task automatic t_counters();
        logic [CNT_W-1:0] c0;
        @(negedge clk); #1;
        c0 = cyc;
        set_mask(1'b0, 32'h0);
        set_mask(1'b1, 32'h0);
        @(negedge clk); #1;
        check("R10 cycle counts on", cyc, CNT_W'(c0 + 5));
        check("R10 masks cleared", m_mask | s_mask, 0);
    endtask

    task automatic t_retire();
        logic [CNT_W-1:0] r0;
        r0 = ret;
        @(negedge clk);
        valid = 1'b1; priv = 2'b11; addr = 12'hC02; wr = 1'b0; retire = 1'b1; #1;
        @(negedge clk);
        valid = 1'b1; priv = 2'b00; addr = 12'hC02; wr = 1'b0; retire = 1'b1; #1;
        check("R11 legal retired", ret, CNT_W'(r0 + 1));
        check("R11 fault flagged", illegal, 1);
        @(negedge clk);
        valid = 1'b0; retire = 1'b0; #1;
        check("R11 fault not retired", ret, CNT_W'(r0 + 1));
        @(negedge clk);
        retire = 1'b1;
        @(negedge clk);
        retire = 1'b0; #1;
        check("R11 plain retire", ret, CNT_W'(r0 + 2));
    endtask

    task automatic t_nos();
        set_mask(1'b0, 32'h0000_0004);
        set_mask(1'b1, 32'h0);
        access(2'b00, 12'hC02, 1'b0);
        check("R12 user by m bit", grant_n, 1);
        check("R12 ref three-level denies", illegal, 1);
        access(2'b01, 12'hC02, 1'b0);
        check("R12 S as user", grant_n, 1);
        access(2'b00, 12'hC01, 1'b0);
        check("R12 clear bit illegal", illegal_n, 1);
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        t_machine();
        t_smode();
        t_umode();
        t_high();
        t_write();
        t_range();
        t_strobe();
        t_cfg_same_cycle();
        t_counters();
        t_retire();
        t_nos();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule